// File: doc/BRIEF.md
# In-Order Commit Unit with Temporary Result Slots

This block lets execution units finish instructions in any order while the architectural register file is still updated in program order. Dispatch claims one slot per instruction, in program order, and gets back the slot index as a tag. The slot records the destination register number. Whenever an execution unit finishes, it uses that tag to write its result and a fault flag into the slot's temporary register, and the unit is then free for new work. Two completion ports let two units report in the same cycle.

The slots form an eight-entry circular buffer. Each cycle the block looks at the oldest one or two slots. A slot whose result is present and has no fault is handed to the register file through one of two write ports, and the oldest slot always goes first. A result that arrives early waits in its slot until every older instruction has been handed over.

When the oldest slot carries a fault, the block signals an exception with that slot's index. In that cycle it writes no register, and at the next edge it discards every slot. No instruction younger than the faulting one can therefore change architectural state, so exceptions are precise.

Top module: `ordered_commit_unit`

## Requirements
- R1: After reset the buffer is empty: `alloc_ready` is 1, `alloc_idx` is 0, and `commit0_valid`, `commit1_valid` and `exc_valid` are 0.
- R2: `alloc_idx` shows the slot that the next accepted allocation takes. Successive accepted allocations get consecutive indices modulo 8, and the first index after reset is 0.
- R3: `alloc_ready` is 0 while 8 slots are held. An `alloc_valid` seen while `alloc_ready` is 0 creates no slot and never leads to a register write.
- R4: A completion that names a held slot marks the slot done and stores its result and fault flag. A completion that names a slot not held is ignored, even if that slot is allocated later.
- R5: `commit0_valid` is 1 in the cycle after the oldest slot's completion edge, if that slot has no fault. `commit0_dest` and `commit0_data` then carry that slot's register number and result, and the slot is freed at the following edge.
- R6: `commit1_valid` presents the second-oldest slot only when that slot is done without fault and `commit0_valid` is also 1, so at most two slots retire per cycle.
- R7: A done slot never retires while any older slot is not done.
- R8: When the oldest slot is done with its fault flag set, `exc_valid` is 1, `exc_idx` equals that slot's index, and both commit ports are 0.
- R9: At the edge that ends a cycle with `exc_valid` set, every slot is discarded. In the next cycle the buffer is empty and `alloc_idx` is 0.
- R10: `alloc_ready` is 0 in a cycle with `exc_valid` set, and an allocation request in that cycle is ignored.
- R11: The two completion ports can write different slots in the same edge, and both results are kept. If both name the same slot, port 1's values win.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Dispatch requests a slot |
| alloc_dest | input | 5 | Destination register of the dispatched instruction |
| alloc_ready | output | 1 | A slot can be taken this cycle |
| alloc_idx | output | 3 | Tag of the slot the next allocation takes |
| cpl0_valid | input | 1 | Completion port 0 writes a slot |
| cpl0_idx | input | 3 | Slot tag for port 0 |
| cpl0_data | input | 32 | Result for port 0 |
| cpl0_fault | input | 1 | Fault flag for port 0 |
| cpl1_valid | input | 1 | Completion port 1 writes a slot |
| cpl1_idx | input | 3 | Slot tag for port 1 |
| cpl1_data | input | 32 | Result for port 1 |
| cpl1_fault | input | 1 | Fault flag for port 1 |
| commit0_valid | output | 1 | Register write of the oldest slot |
| commit0_dest | output | 5 | Register number for write 0 |
| commit0_data | output | 32 | Value for write 0 |
| commit1_valid | output | 1 | Register write of the second-oldest slot |
| commit1_dest | output | 5 | Register number for write 1 |
| commit1_data | output | 32 | Value for write 1 |
| exc_valid | output | 1 | Oldest slot faulted; the buffer is discarded |
| exc_idx | output | 3 | Index of the faulting slot |

## Verification
`alloc_ready` and `alloc_idx` depend only on registered state, so they are due in the same cycle. A completion at edge N makes the commit or exception outputs valid right after edge N, and the slot is freed at edge N+1. A fault empties the whole buffer at the edge that ends the exception cycle. The bench drives inputs just after the falling edge and samples one nanosecond later, before the rising edge. At that point it compares every output with a behavioural model of the slots, then advances the model at the rising edge with the same inputs the design sees.

// File: rtl/ocu_pkg.sv
package ocu_pkg;
    parameter int unsigned DEST_W = 5;
    parameter int unsigned DATA_W = 32;

    typedef struct packed {
        logic              valid;
        logic              done;
        logic              fault;
        logic [DEST_W-1:0] dest;
        logic [DATA_W-1:0] data;
    } slot_t;
endpackage

// File: rtl/ocu_slot.sv
module ocu_slot
    import ocu_pkg::*;
#(
    parameter int unsigned IDX_W  = 3,
    parameter int unsigned MY_IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              alloc_hit,
    input  logic [DEST_W-1:0] alloc_dest,
    input  logic              retire_hit,
    input  logic              c0_valid,
    input  logic [IDX_W-1:0]  c0_idx,
    input  logic [DATA_W-1:0] c0_data,
    input  logic              c0_fault,
    input  logic              c1_valid,
    input  logic [IDX_W-1:0]  c1_idx,
    input  logic [DATA_W-1:0] c1_data,
    input  logic              c1_fault,
    output slot_t             slot_o
);
    slot_t slot_d, slot_q;
    logic  c0_hit, c1_hit;

    always_comb begin
        slot_d = slot_q;
        c0_hit = c0_valid && (c0_idx == IDX_W'(MY_IDX)) && slot_q.valid;
        c1_hit = c1_valid && (c1_idx == IDX_W'(MY_IDX)) && slot_q.valid;
        if (c0_hit) begin
            slot_d.done  = 1'b1;
            slot_d.fault = c0_fault;
            slot_d.data  = c0_data;
        end
        if (c1_hit) begin
            slot_d.done  = 1'b1;
            slot_d.fault = c1_fault;
            slot_d.data  = c1_data;
        end
        if (alloc_hit) begin
            slot_d.valid = 1'b1;
            slot_d.done  = 1'b0;
            slot_d.fault = 1'b0;
            slot_d.dest  = alloc_dest;
        end
        if (retire_hit || flush) begin
            slot_d.valid = 1'b0;
            slot_d.done  = 1'b0;
            slot_d.fault = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign slot_o = slot_q;

    // R4: a slot only becomes done through a completion that hit it
    a_r4_done_needs_cpl: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slot_q.done) |-> $past(c0_hit || c1_hit));

    // R3: allocation never overwrites a held slot
    a_r3_alloc_free_slot: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_hit |-> !slot_q.valid);
endmodule

// File: rtl/ocu_ptr_ctrl.sv
module ocu_ptr_ctrl #(
    parameter  int unsigned DEPTH = 8,
    localparam int unsigned IDX_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_fire,
    input  logic [1:0]       retire_cnt,
    input  logic             flush,
    output logic [IDX_W-1:0] head_o,
    output logic [IDX_W-1:0] head_nxt_o,
    output logic [IDX_W-1:0] tail_o,
    output logic [CNT_W-1:0] count_o
);
    typedef struct packed {
        logic [IDX_W-1:0] head;
        logic [IDX_W-1:0] tail;
        logic [CNT_W-1:0] count;
    } ptr_t;

    ptr_t ptr_d, ptr_q;

    function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] p, input logic [1:0] n);
        logic [IDX_W+1:0] s;
        s = {2'b00, p} + {{IDX_W{1'b0}}, n};
        if (s >= (IDX_W+2)'(DEPTH)) s = s - (IDX_W+2)'(DEPTH);
        return s[IDX_W-1:0];
    endfunction

    always_comb begin
        ptr_d = ptr_q;
        if (flush) begin
            ptr_d = '0;
        end else begin
            ptr_d.head  = bump(ptr_q.head, retire_cnt);
            ptr_d.tail  = alloc_fire ? bump(ptr_q.tail, 2'd1) : ptr_q.tail;
            ptr_d.count = ptr_q.count - CNT_W'(retire_cnt) + CNT_W'(alloc_fire);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign head_o     = ptr_q.head;
    assign head_nxt_o = bump(ptr_q.head, 2'd1);
    assign tail_o     = ptr_q.tail;
    assign count_o    = ptr_q.count;

    // R3: occupancy never passes the slot count
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q.count <= CNT_W'(DEPTH));

    // R9: a flush leaves the buffer empty with both pointers at zero
    a_r9_flush_resets: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (ptr_q.count == '0) && (ptr_q.head == '0) && (ptr_q.tail == '0));

    // R2: an accepted allocation moves the tag on by one
    a_r2_tail_step: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_fire && !flush) |=> ptr_q.tail == bump($past(ptr_q.tail), 2'd1));

    // R6: never more slots retire than are held
    a_r6_retire_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        CNT_W'(retire_cnt) <= ptr_q.count);
endmodule

// File: rtl/ocu_retire_pick.sv
module ocu_retire_pick (
    input  logic old_valid,
    input  logic old_done,
    input  logic old_fault,
    input  logic nxt_valid,
    input  logic nxt_done,
    input  logic nxt_fault,
    output logic take0,
    output logic take1,
    output logic fault
);
    logic old_ready, nxt_ready;

    always_comb begin
        old_ready = old_valid && old_done;
        nxt_ready = nxt_valid && nxt_done && !nxt_fault;
        fault     = old_ready && old_fault;
        take0     = old_ready && !old_fault;
        take1     = take0 && nxt_ready;
    end
endmodule

// File: rtl/ordered_commit_unit.sv
module ordered_commit_unit
    import ocu_pkg::*;
#(
    parameter  int unsigned DEPTH = 8,
    localparam int unsigned IDX_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [DEST_W-1:0] alloc_dest,
    output logic              alloc_ready,
    output logic [IDX_W-1:0]  alloc_idx,
    input  logic              cpl0_valid,
    input  logic [IDX_W-1:0]  cpl0_idx,
    input  logic [DATA_W-1:0] cpl0_data,
    input  logic              cpl0_fault,
    input  logic              cpl1_valid,
    input  logic [IDX_W-1:0]  cpl1_idx,
    input  logic [DATA_W-1:0] cpl1_data,
    input  logic              cpl1_fault,
    output logic              commit0_valid,
    output logic [DEST_W-1:0] commit0_dest,
    output logic [DATA_W-1:0] commit0_data,
    output logic              commit1_valid,
    output logic [DEST_W-1:0] commit1_dest,
    output logic [DATA_W-1:0] commit1_data,
    output logic              exc_valid,
    output logic [IDX_W-1:0]  exc_idx
);
    logic [IDX_W-1:0] head, head_nxt, tail;
    logic [CNT_W-1:0] count;
    logic             take0, take1, fault;
    logic             alloc_fire;
    logic [1:0]       retire_cnt;
    slot_t            slots [DEPTH];
    slot_t            oldest, second;

    assign oldest      = slots[head];
    assign second      = slots[head_nxt];
    assign alloc_ready = (count != CNT_W'(DEPTH)) && !fault;
    assign alloc_fire  = alloc_valid && alloc_ready;
    assign retire_cnt  = 2'(take0) + 2'(take1);

    ocu_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_fire (alloc_fire),
        .retire_cnt (retire_cnt),
        .flush      (fault),
        .head_o     (head),
        .head_nxt_o (head_nxt),
        .tail_o     (tail),
        .count_o    (count)
    );

    ocu_retire_pick u_pick (
        .old_valid (oldest.valid),
        .old_done  (oldest.done),
        .old_fault (oldest.fault),
        .nxt_valid (second.valid),
        .nxt_done  (second.done),
        .nxt_fault (second.fault),
        .take0     (take0),
        .take1     (take1),
        .fault     (fault)
    );

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic hit_alloc, hit_retire;
        assign hit_alloc  = alloc_fire && (tail == IDX_W'(g));
        assign hit_retire = (take0 && (head == IDX_W'(g))) ||
                            (take1 && (head_nxt == IDX_W'(g)));
        ocu_slot #(.IDX_W(IDX_W), .MY_IDX(g)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .flush      (fault),
            .alloc_hit  (hit_alloc),
            .alloc_dest (alloc_dest),
            .retire_hit (hit_retire),
            .c0_valid   (cpl0_valid),
            .c0_idx     (cpl0_idx),
            .c0_data    (cpl0_data),
            .c0_fault   (cpl0_fault),
            .c1_valid   (cpl1_valid),
            .c1_idx     (cpl1_idx),
            .c1_data    (cpl1_data),
            .c1_fault   (cpl1_fault),
            .slot_o     (slots[g])
        );
    end

    assign alloc_idx     = tail;
    assign commit0_valid = take0;
    assign commit0_dest  = oldest.dest;
    assign commit0_data  = oldest.data;
    assign commit1_valid = take1;
    assign commit1_dest  = second.dest;
    assign commit1_data  = second.data;
    assign exc_valid     = fault;
    assign exc_idx       = head;

    // R8: a faulting oldest slot blocks both register writes
    a_r8_fault_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> !commit0_valid && !commit1_valid);

    // R6: the second write port only follows the first
    a_r6_pair_needs_first: assert property (@(posedge clk) disable iff (!rst_n)
        commit1_valid |-> commit0_valid);

    // R9: the cycle after an exception is quiet
    a_r9_quiet_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |=> !commit0_valid && !exc_valid && alloc_ready);
endmodule

// File: tb/ordered_commit_unit_tb.sv
`timescale 1ns/1ps
module ordered_commit_unit_tb;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_valid, alloc_ready;
    logic [4:0]  alloc_dest;
    logic [2:0]  alloc_idx;
    logic        cpl0_valid, cpl0_fault, cpl1_valid, cpl1_fault;
    logic [2:0]  cpl0_idx, cpl1_idx;
    logic [31:0] cpl0_data, cpl1_data;
    logic        commit0_valid, commit1_valid, exc_valid;
    logic [4:0]  commit0_dest, commit1_dest;
    logic [31:0] commit0_data, commit1_data;
    logic [2:0]  exc_idx;

    ordered_commit_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_dest(alloc_dest),
        .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
        .cpl0_valid(cpl0_valid), .cpl0_idx(cpl0_idx), .cpl0_data(cpl0_data), .cpl0_fault(cpl0_fault),
        .cpl1_valid(cpl1_valid), .cpl1_idx(cpl1_idx), .cpl1_data(cpl1_data), .cpl1_fault(cpl1_fault),
        .commit0_valid(commit0_valid), .commit0_dest(commit0_dest), .commit0_data(commit0_data),
        .commit1_valid(commit1_valid), .commit1_dest(commit1_dest), .commit1_data(commit1_data),
        .exc_valid(exc_valid), .exc_idx(exc_idx)
    );

    always #2 clk = ~clk;

    int checks = 0, errors = 0, ncommit = 0;
    bit finished = 0;
    logic [31:0] seed = 32'h1234_5678;

    bit          m_v [DEPTH], m_d [DEPTH], m_f [DEPTH];
    int          m_dest [DEPTH];
    logic [31:0] m_data [DEPTH];
    int          m_head = 0, m_tail = 0, m_count = 0;
    bit          exp_c0, exp_c1, exp_ex, exp_rdy;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    task automatic idle_in();
        alloc_valid = 0; alloc_dest = '0;
        cpl0_valid = 0; cpl0_idx = '0; cpl0_data = '0; cpl0_fault = 0;
        cpl1_valid = 0; cpl1_idx = '0; cpl1_data = '0; cpl1_fault = 0;
    endtask

    task automatic compare_all();
        int h1;
        h1      = (m_head + 1) % DEPTH;
        exp_ex  = m_v[m_head] && m_d[m_head] && m_f[m_head];
        exp_c0  = m_v[m_head] && m_d[m_head] && !m_f[m_head];
        exp_c1  = exp_c0 && m_v[h1] && m_d[h1] && !m_f[h1];
        exp_rdy = (m_count < DEPTH) && !exp_ex;
        chk("R3/R10 alloc_ready", alloc_ready, exp_rdy);
        chk("R2 alloc_idx", alloc_idx, m_tail);
        chk("R8 exc_valid", exc_valid, exp_ex);
        if (exp_ex) chk("R8 exc_idx", exc_idx, m_head);
        chk("R5/R7 commit0_valid", commit0_valid, exp_c0);
        if (exp_c0) begin
            chk("R5 commit0_dest", commit0_dest, m_dest[m_head]);
            chk("R5 commit0_data", commit0_data, m_data[m_head]);
        end
        chk("R6 commit1_valid", commit1_valid, exp_c1);
        if (exp_c1) begin
            chk("R6 commit1_dest", commit1_dest, m_dest[h1]);
            chk("R6 commit1_data", commit1_data, m_data[h1]);
        end
        if (commit0_valid) ncommit++;
        if (commit1_valid) ncommit++;
    endtask

    task automatic model_update();
        int n;
        if (cpl0_valid && m_v[cpl0_idx]) begin
            m_d[cpl0_idx] = 1; m_f[cpl0_idx] = cpl0_fault; m_data[cpl0_idx] = cpl0_data;
        end
        if (cpl1_valid && m_v[cpl1_idx]) begin
            m_d[cpl1_idx] = 1; m_f[cpl1_idx] = cpl1_fault; m_data[cpl1_idx] = cpl1_data;
        end
        if (exp_ex) begin
            for (int k = 0; k < DEPTH; k++) begin m_v[k] = 0; m_d[k] = 0; m_f[k] = 0; end
            m_head = 0; m_tail = 0; m_count = 0;
        end else begin
            n = int'(exp_c0) + int'(exp_c1);
            for (int k = 0; k < n; k++) begin
                m_v[(m_head + k) % DEPTH] = 0;
                m_d[(m_head + k) % DEPTH] = 0;
            end
            m_head  = (m_head + n) % DEPTH;
            m_count = m_count - n;
            if (alloc_valid && exp_rdy) begin
                m_v[m_tail] = 1; m_d[m_tail] = 0; m_f[m_tail] = 0;
                m_dest[m_tail] = int'(alloc_dest);
                m_tail  = (m_tail + 1) % DEPTH;
                m_count = m_count + 1;
            end
        end
    endtask

    task automatic cycle();
        #1;
        compare_all();
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic alloc_one(input logic [4:0] d);
        alloc_valid = 1; alloc_dest = d;
        cycle();
        alloc_valid = 0;
    endtask

    task automatic cpl(input bit p0, input int i0, input logic [31:0] d0, input bit f0,
                       input bit p1, input int i1, input logic [31:0] d1, input bit f1);
        cpl0_valid = p0; cpl0_idx = 3'(i0); cpl0_data = d0; cpl0_fault = f0;
        cpl1_valid = p1; cpl1_idx = 3'(i1); cpl1_data = d1; cpl1_fault = f1;
        cycle();
        idle_in();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle_in();
        for (int k = 0; k < DEPTH; k++) begin m_v[k] = 0; m_d[k] = 0; m_f[k] = 0; m_dest[k] = 0; m_data[k] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 alloc_ready", alloc_ready, 1);
        chk("R1 alloc_idx", alloc_idx, 0);
        chk("R1 commit0_valid", commit0_valid, 0);
        chk("R1 commit1_valid", commit1_valid, 0);
        chk("R1 exc_valid", exc_valid, 0);

        // R2 sequential tags, R7 wait, R11 dual completion, R5/R6 ordered pair
        alloc_one(5'd1);
        chk("R2 second tag", alloc_idx, 1);
        alloc_one(5'd2);
        chk("R2 third tag", alloc_idx, 2);
        alloc_one(5'd3);
        cpl(1, 2, 32'hC2, 0, 1, 1, 32'hC1, 0);
        chk("R7 younger done waits", commit0_valid, 0);
        cpl(1, 0, 32'hC0, 0, 0, 0, 0, 0);
        chk("R5 commit0_dest", commit0_dest, 1);
        chk("R5 commit0_data", commit0_data, 32'hC0);
        chk("R6 commit1_valid", commit1_valid, 1);
        chk("R6 commit1_dest", commit1_dest, 2);
        chk("R11 port1 result kept", commit1_data, 32'hC1);
        cycle();
        chk("R5 third commit dest", commit0_dest, 3);
        chk("R11 port0 result kept", commit0_data, 32'hC2);
        chk("R6 no second", commit1_valid, 0);
        cycle();

        // R3 full buffer, wrapped tags, ignored request
        ncommit = 0;
        for (int k = 0; k < DEPTH; k++) begin
            chk("R2 wrap tag", alloc_idx, (3 + k) % DEPTH);
            alloc_one(5'(10 + k));
        end
        chk("R3 full", alloc_ready, 0);
        alloc_valid = 1; alloc_dest = 5'd31;
        cycle();
        alloc_valid = 0;
        chk("R3 still full", alloc_ready, 0);
        chk("R3 tag unchanged", alloc_idx, 3);
        for (int k = 0; k < 4; k++)
            cpl(1, (3 + 2*k) % DEPTH, 32'h100 + 32'(2*k), 0, 1, (4 + 2*k) % DEPTH, 32'h101 + 32'(2*k), 0);
        repeat (6) cycle();
        chk("R3 ignored request never commits", ncommit, 8);

        // R8 fault at third slot, R10 blocked allocation, R9 flush
        alloc_one(5'd4); alloc_one(5'd5); alloc_one(5'd6); alloc_one(5'd7);
        cpl(1, 3, 32'hA3, 0, 1, 4, 32'hA4, 0);
        chk("R6 pair before fault", commit1_valid, 1);
        cpl(1, 5, 32'hA5, 1, 1, 6, 32'hA6, 0);
        chk("R8 exc_valid", exc_valid, 1);
        chk("R8 exc_idx", exc_idx, 5);
        chk("R8 no commit", commit0_valid, 0);
        chk("R10 alloc blocked", alloc_ready, 0);
        alloc_valid = 1; alloc_dest = 5'd9;
        cycle();
        alloc_valid = 0;
        chk("R9 empty ready", alloc_ready, 1);
        chk("R9 tag restart", alloc_idx, 0);
        chk("R9 no commit", commit0_valid, 0);
        chk("R9 no exc", exc_valid, 0);

        // R4 completion to a slot not held is ignored
        cpl(1, 0, 32'hDEAD, 0, 0, 0, 0, 0);
        alloc_one(5'd8);
        chk("R4 stale completion ignored", commit0_valid, 0);
        cpl(1, 0, 32'h55, 0, 0, 0, 0, 0);
        chk("R4 live completion", commit0_valid, 1);
        chk("R4 live data", commit0_data, 32'h55);
        cycle();

        // mixed traffic against the model (R2..R11)
        repeat (3000) begin
            logic [31:0] r;
            int off, p0, p1;
            r = rnd();
            alloc_valid = r[0] | r[1];
            alloc_dest  = r[6:2];
            off = int'(r[9:7]);
            p0 = -1; p1 = -1;
            for (int k = 0; k < DEPTH; k++) begin
                int j;
                j = (off + k) % DEPTH;
                if (m_v[j] && !m_d[j]) begin
                    if (p0 < 0) p0 = j;
                    else if (p1 < 0) p1 = j;
                end
            end
            if (p0 >= 0 && r[10]) begin
                cpl0_valid = 1; cpl0_idx = 3'(p0); cpl0_data = rnd(); cpl0_fault = (r[15:11] == 0);
            end
            if (p1 >= 0 && r[16]) begin
                cpl1_valid = 1; cpl1_idx = 3'(p1); cpl1_data = rnd(); cpl1_fault = (r[21:17] == 0);
            end
            cycle();
            idle_in();
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule